// File: doc/BRIEF.md
# Uninitialized Working-Register Pointer Guard

This block keeps one "written since reset" bit for each entry of a small working register file. Any reset clears those bits, and each write to an entry sets that entry's bit. The block watches the strobe that marks an entry being used as an address pointer. If the entry used has never been written since the last reset, the block sends a reset request to the reset sequencer. The register data itself, the decoder and the sequencer are outside this block.

The top entry, normally the stack pointer, is exempt. Reset never clears it, it always reads as initialized, and pointer use of it never raises a request. Only pointer use is checked, so writes alone never cause a request. The request comes from a two-state machine:
- `ST_ARMED`: the machine waits for an illegal use. It moves to `ST_FIRE` on a violation and otherwise stays.
- `ST_FIRE`: `rst_req` is high. The machine always returns to `ST_ARMED` on the next edge.

A synchronous reset event (`soft_rst`) has priority over everything else in its cycle.

Top module: `wreg_init_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `reg_valid` equals 16'h8000 and `rst_req` is 0.
- R2: A `soft_rst` cycle clears `reg_valid` bits 0 to 14 at the next edge. Bit 15 stays at 1.
- R3: `reg_valid[15]` is 1 at all times. A write to index 15 has no visible effect, and pointer use of index 15 never raises `rst_req`.
- R4: A write (`wr_en`=1, `soft_rst`=0) to an index 0 to 14 sets that bit of `reg_valid` at the next edge. The bit stays set until a reset.
- R5: A pointer use (`ptr_en`=1, `soft_rst`=0) of an index whose `reg_valid` bit is 0 raises `rst_req` after the next edge, for exactly one cycle, while the machine is in `ST_ARMED`.
- R6: A pointer use of an index whose `reg_valid` bit is 1 does not raise `rst_req`.
- R7: If a write and a pointer use name the same uninitialized index in the same cycle, the pointer use is still illegal and raises `rst_req`. The write still sets the bit.
- R8: When `ptr_en` is 0, `rst_req` stays 0 in the next cycle, whatever values `wr_en`, `wr_idx` and `ptr_idx` have.
- R9: In a `soft_rst` cycle, a write does not set a bit, a pointer use is not checked, and `rst_req` is 0 in the next cycle.
- R10: A violation that arrives while `rst_req` is high (state `ST_FIRE`) is dropped. `rst_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous reset event of any kind |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Index of the register written |
| ptr_en | input | 1 | Address-pointer use strobe |
| ptr_idx | input | 4 | Index of the register used as a pointer |
| rst_req | output | 1 | One-cycle reset request |
| reg_valid | output | 16 | Written-since-reset bit for each register |

## Verification
Two functions can fall in the same cycle: a write that initializes an entry, and a pointer use that tests it. The bench sweeps every pair of write index and pointer index after a clean reset and drives both strobes in one cycle. It expects a request only when the pointer index is not 15, because the check must use the state from before the write. It then checks that the written bit is set. A second collision sweep adds `soft_rst` to the same cycle, and there the reset must suppress both the write and the check.

// File: rtl/wig_pkg.sv
package wig_pkg;
    // States of the request machine
    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_FIRE  = 1'b1
    } req_state_e;
endpackage

// File: rtl/wig_valid_track.sv
module wig_valid_track #(
    parameter int NUM_REGS   = 16,
    parameter int EXEMPT_IDX = NUM_REGS - 1,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    output logic [NUM_REGS-1:0] valid_o
);
    // One flag per entry; the exempt entry is a constant one
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        if (i == EXEMPT_IDX) begin : g_pinned
            assign valid_o[i] = 1'b1;
        end else begin : g_flag
            logic hit;
            logic flag_q;
            assign hit = wr_en && (wr_idx == IDX_W'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (soft_rst) begin
                    flag_q <= 1'b0;
                end else if (hit) begin
                    flag_q <= 1'b1;
                end
            end
            assign valid_o[i] = flag_q;
        end
    end
endmodule

// File: rtl/wig_ptr_check.sv
module wig_ptr_check #(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                soft_rst,
    input  logic                ptr_en,
    input  logic [IDX_W-1:0]    ptr_idx,
    input  logic [NUM_REGS-1:0] valid_i,
    output logic                violation_o
);
    // valid_i is the registered state, i.e. before any same-cycle write
    logic sel_valid;
    always_comb begin
        sel_valid = valid_i[ptr_idx];
        violation_o = ptr_en && !soft_rst && !sel_valid;
    end
endmodule

// File: rtl/wig_req_fsm.sv
module wig_req_fsm
    import wig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic violation_i,
    output logic req_o
);
    req_state_e state_q;
    req_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (violation_i && !soft_rst) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                state_d = ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        req_o = 1'b0;
        unique case (state_q)
            ST_ARMED: req_o = 1'b0;
            ST_FIRE:  req_o = 1'b1;
            default:  req_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/wreg_init_guard.sv
module wreg_init_guard #(
    parameter int NUM_REGS   = 16,
    parameter int EXEMPT_IDX = NUM_REGS - 1,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                ptr_en,
    input  logic [IDX_W-1:0]    ptr_idx,
    output logic                rst_req,
    output logic [NUM_REGS-1:0] reg_valid
);
    logic violation;

    wig_valid_track #(
        .NUM_REGS   (NUM_REGS),
        .EXEMPT_IDX (EXEMPT_IDX)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .valid_o  (reg_valid)
    );

    wig_ptr_check #(
        .NUM_REGS (NUM_REGS)
    ) u_check (
        .soft_rst    (soft_rst),
        .ptr_en      (ptr_en),
        .ptr_idx     (ptr_idx),
        .valid_i     (reg_valid),
        .violation_o (violation)
    );

    wig_req_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .violation_i (violation),
        .req_o       (rst_req)
    );
endmodule

// File: rtl/wig_checker.sv
module wig_checker #(
    parameter int NUM_REGS   = 16,
    parameter int EXEMPT_IDX = NUM_REGS - 1,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                soft_rst,
    input logic                wr_en,
    input logic [IDX_W-1:0]    wr_idx,
    input logic                ptr_en,
    input logic [IDX_W-1:0]    ptr_idx,
    input logic                rst_req,
    input logic [NUM_REGS-1:0] reg_valid
);
    localparam logic [NUM_REGS-1:0] EX_MASK =
        {{(NUM_REGS-1){1'b0}}, 1'b1} << EXEMPT_IDX;

    // R3
    pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid[EXEMPT_IDX]);

    // R2
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((reg_valid & ~EX_MASK) == '0));

    // R4
    write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> reg_valid[$past(wr_idx)]);

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((reg_valid & $past(reg_valid)) == $past(reg_valid)));

    // R5
    illegal_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && !soft_rst && !reg_valid[ptr_idx] && !rst_req) |=> rst_req);

    // R6
    legal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && reg_valid[ptr_idx]) |=> !rst_req);

    // R7
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && wr_en && wr_idx == ptr_idx && !reg_valid[ptr_idx]
         && !soft_rst && !rst_req) |=> rst_req);

    // R8
    no_ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_en |=> !rst_req);

    // R9
    srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !rst_req);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

bind wreg_init_guard wig_checker #(
    .NUM_REGS   (NUM_REGS),
    .EXEMPT_IDX (EXEMPT_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .ptr_en    (ptr_en),
    .ptr_idx   (ptr_idx),
    .rst_req   (rst_req),
    .reg_valid (reg_valid)
);

// File: tb/tb_wreg_init_guard.sv
`timescale 1ns/1ps
module tb_wreg_init_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        ptr_en = 1'b0;
    logic [3:0]  ptr_idx = '0;
    logic        rst_req;
    logic [15:0] reg_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model built from the requirements
    logic [15:0] m_valid;
    logic        m_req;

    always #2 clk = ~clk;

    wreg_init_guard dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .ptr_en    (ptr_en),
        .ptr_idx   (ptr_idx),
        .rst_req   (rst_req),
        .reg_valid (reg_valid)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, advance one edge, compare at the next negedge
    task automatic step(input string tag, input logic sr, input logic we, input int wi,
                        input logic pe, input int pi);
        logic nreq;
        soft_rst = sr; wr_en = we; wr_idx = 4'(wi); ptr_en = pe; ptr_idx = 4'(pi);
        nreq = !sr && pe && !m_valid[pi] && !m_req;
        if (sr) m_valid = 16'h8000;
        else if (we) m_valid = m_valid | (16'h1 << wi);
        m_valid[15] = 1'b1;
        m_req = nreq;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " rst_req"}, {15'd0, rst_req}, {15'd0, m_req});
        chk({tag, " reg_valid"}, reg_valid, m_valid);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 0, 1'b0, 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        m_valid = 16'h8000;
        m_req = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 in-reset valid", reg_valid, 16'h8000);
        chk("R1 in-reset req", {15'd0, rst_req}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset valid", reg_valid, 16'h8000);
        chk("R1 post-reset req", {15'd0, rst_req}, 16'd0);

        // R5 / R3: pointer use before any write
        for (int p = 0; p < 16; p++) begin
            step(p == 15 ? "R3 ptr exempt" : "R5 ptr unwritten", 1'b0, 1'b0, 0, 1'b1, p);
            idle("R5 pulse ends");
        end

        // R8 / R4: writes alone, pointer index wiggling with ptr_en low
        for (int w = 0; w < 16; w++) begin
            step("R8 write only", 1'b0, 1'b1, w, 1'b0, 15 - w);
        end
        chk("R4 all written", reg_valid, 16'hFFFF);

        // R6: every entry now legal
        for (int p = 0; p < 16; p++) begin
            step("R6 ptr legal", 1'b0, 1'b0, 0, 1'b1, p);
        end

        // R2: reset event
        step("R2 soft reset", 1'b1, 1'b0, 0, 1'b0, 0);

        // R7: every write/pointer pair in one cycle
        for (int w = 0; w < 16; w++) begin
            for (int p = 0; p < 16; p++) begin
                step("R2 clear", 1'b1, 1'b0, 0, 1'b0, 0);
                step("R7 same cycle", 1'b0, 1'b1, w, 1'b1, p);
                idle("R10 gap");
                step(p == w ? "R6 after write" : "R5 other unwritten", 1'b0, 1'b0, 0, 1'b1, p);
                idle("R10 gap");
            end
        end

        // R9: reset event colliding with write and pointer use
        for (int i = 0; i < 16; i++) begin
            step("R9 write", 1'b0, 1'b1, i, 1'b0, 0);
            step("R9 collide", 1'b1, 1'b1, (i + 3) % 16, 1'b1, (i + 5) % 15);
            step("R9 after", 1'b0, 1'b0, 0, 1'b0, 0);
        end

        // R10: back-to-back violations
        step("R2 clear", 1'b1, 1'b0, 0, 1'b0, 0);
        step("R10 first", 1'b0, 1'b0, 0, 1'b1, 3);
        step("R10 dropped", 1'b0, 1'b0, 0, 1'b1, 4);
        step("R10 rearmed", 1'b0, 1'b0, 0, 1'b1, 4);
        idle("R10 end");

        // R4 / R5: pseudo-random traffic
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R4 random", (lfsr[15:10] == 6'h3F), lfsr[0], int'(lfsr[4:1]),
                 lfsr[5] & lfsr[6], int'(lfsr[10:7]));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule